// File: doc/BRIEF.md
# AUX Channel Transaction Register Controller

This block is the software-facing front end of a DisplayPort AUX channel. Software runs one transaction at a time through a small word-addressed register file. It loads a target address, up to sixteen transmit bytes and a control word that holds the command code and the byte count minus one. It then sets a go bit. The controller presents the request on a link-side port with a valid/ready handshake and waits for a single-cycle reply. It stores the reply type, the received byte count, the received bytes and any link error flags, and then raises a done interrupt flag.

The controller also runs a reply watchdog. If the link side stays silent for too long, the transaction ends with a timeout flag. The block also tracks the hot-plug-detect input: it reports the synchronised level and flags each plug and unplug edge. A sink-interrupt pulse from the link side lands in its own flag. All interrupt flags are write-one-to-clear, and the interrupt line is the OR of the flags that are enabled. The serialiser, the analog pads and the pad mode are outside this block.

Register word offsets (byte address = offset x 4):

| Register | Word offset | Byte address |
|---|---|---|
| ADDR | 0 | 0x00 |
| CTRL | 1 | 0x04 |
| STAT | 2 | 0x08 |
| IEN | 3 | 0x0C |
| IFLAG | 4 | 0x10 |
| TX words 0..3 | 8..11 | 0x20..0x2C |
| RX words 0..3 | 12..15 | 0x30..0x3C |

Any other offset reads as zero.

Top module: `aux_xact_ctrl`

## Requirements
- R1: A legal start drives the request with fixed values. `lk_req_cmd` equals CTRL[11:8] and `lk_req_addr` equals the ADDR register. `lk_req_len` equals CTRL[3:0]+1 (range 1 to 16), or 0 when the address-only bit CTRL[12] is set. `lk_req_valid` stays high until `lk_req_ready` is seen.
- R2: TX word w sits at word offset 8+w. Request byte k, `lk_req_data[8k+7:8k]`, equals bits 8(k mod 4)+7 down to 8(k mod 4) of TX word k/4, so the bytes are packed little-endian.
- R3: The legal command codes are:
  - I2C write 0x0, I2C read 0x1, I2C write-status-update 0x2;
  - their middle-of-transaction variants 0x4, 0x5 and 0x6;
  - native write 0x8 and native read 0x9.

  The address-only bit is legal only with the I2C codes. A go write with an undefined code, or with address-only on a native code, is ignored: no request is made, the go bit stays 0 and no done flag is set.
- R4: The go bit CTRL[16] reads 1 from the start until completion and then clears itself. While it is 1, writes to CTRL, ADDR and the TX words are ignored.
- R5: When a reply arrives, STAT[19:16] takes the reply type code and STAT[4:0] takes the received byte count. RX word w at word offset 12+w holds reply bytes 4w to 4w+3, packed little-endian as in R2. The reply type codes are 0x0 native ACK, 0x1 native NACK, 0x2 native DEFER, 0x4 I2C NACK and 0x8 I2C DEFER.
- R6: The link error inputs map to sticky STAT flags: `lk_rsp_err[0]` (receive error) sets bit 9, `lk_rsp_err[1]` (sink status error) sets bit 10 and `lk_rsp_err[2]` (missing stop) sets bit 11. Writing 1 to any of bits 11..8 clears that flag, writing 0 leaves it, and writing 0xF00 clears all four.
- R7: If no reply arrives within TIMEOUT_CYC cycles of the start, the controller does three things. It sets STAT bit 8, sets the byte count to 0, and withdraws the request. The transaction still completes with the done flag. A reply that arrives afterwards is ignored.
- R8: Every completed transaction sets IFLAG bit 0 (done).
- R9: STAT bit 24 shows the hot-plug level after a two-stage synchroniser. A rising edge of that level sets IFLAG bit 1 (plug), and a falling edge sets IFLAG bit 2 (unplug).
- R10: A high cycle on `sink_irq` sets IFLAG bit 3.
- R11: Writing 1 to an IFLAG bit clears it. `irq` is high exactly when some IFLAG bit and the matching IEN bit (bits 3..0) are both 1.
- R12: After reset every register reads 0, and both `irq` and `lk_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_word | input | 4 | Register word offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_word` (combinational) |
| irq | output | 1 | Interrupt, OR of enabled flags |
| lk_req_valid | output | 1 | Request pending towards the link side |
| lk_req_ready | input | 1 | Link side accepts the request |
| lk_req_cmd | output | 4 | Command code |
| lk_req_addr | output | 20 | Target address |
| lk_req_len | output | 5 | Byte count, 0 for address-only |
| lk_req_data | output | 128 | Transmit bytes, little-endian packed |
| lk_rsp_valid | input | 1 | Reply present for one cycle |
| lk_rsp_type | input | 4 | Reply type code |
| lk_rsp_len | input | 5 | Received byte count |
| lk_rsp_data | input | 128 | Received bytes, little-endian packed |
| lk_rsp_err | input | 3 | Receive, sink-status and missing-stop errors |
| hpd_in | input | 1 | Asynchronous hot-plug-detect level |
| sink_irq | input | 1 | Sink interrupt event pulse |

## Verification
The transaction path is tried with four shapes, each of which tells a different field mapping apart:
- a five-byte native write, which checks the length-minus-one arithmetic and the transmit byte order;
- a full sixteen-byte middle-of-transaction I2C read, which checks the top length value and the receive packing;
- an address-only status-update request, which must drive a zero length;
- a native read whose control and address registers are rewritten while it is busy, which must leave the request unchanged.

Illegal command and address-only combinations check that the go bit is dropped. A reply with mixed error bits, followed by partial and full clears, checks that each error flag is sticky and cleared separately. A silent link, followed by a late reply, checks the watchdog length and that the late reply is discarded. Hot-plug edges in both directions, sink pulses, and changes to the enable mask check the flag mapping and the gating of the interrupt line.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;

    // Data buffer geometry: 16 bytes, four 32-bit words
    localparam int BUF_BYTES = 16;
    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int BUF_BITS  = BUF_BYTES * 8;
    localparam int CNT_W     = $clog2(BUF_BYTES + 1);
    localparam int LENF_W    = $clog2(BUF_BYTES);
    localparam int REG_IDX_W = 4;
    localparam int LERR_N    = 3;
    localparam int SERR_N    = LERR_N + 1;
    localparam int INT_N     = 4;

    // Register word offsets
    localparam logic [REG_IDX_W-1:0] IDX_ADDR    = 4'd0;
    localparam logic [REG_IDX_W-1:0] IDX_CTRL    = 4'd1;
    localparam logic [REG_IDX_W-1:0] IDX_STAT    = 4'd2;
    localparam logic [REG_IDX_W-1:0] IDX_IEN     = 4'd3;
    localparam logic [REG_IDX_W-1:0] IDX_IFLAG   = 4'd4;
    localparam logic [REG_IDX_W-1:0] IDX_TX_BASE = 4'd8;
    localparam logic [REG_IDX_W-1:0] IDX_RX_BASE = 4'd12;

    // Field positions
    localparam int CTRL_CMD_LSB   = 8;
    localparam int CTRL_AONLY_BIT = 12;
    localparam int CTRL_GO_BIT    = 16;
    localparam int STAT_ERR_LSB   = 8;
    localparam int STAT_TYPE_LSB  = 16;
    localparam int STAT_HPD_BIT   = 24;

    // Interrupt flag bits
    localparam int INT_DONE   = 0;
    localparam int INT_PLUG   = 1;
    localparam int INT_UNPLUG = 2;
    localparam int INT_SINK   = 3;

    typedef enum logic [3:0] {
        CMD_I2C_WR      = 4'h0,
        CMD_I2C_RD      = 4'h1,
        CMD_I2C_WSU     = 4'h2,
        CMD_I2C_WR_MOT  = 4'h4,
        CMD_I2C_RD_MOT  = 4'h5,
        CMD_I2C_WSU_MOT = 4'h6,
        CMD_NAT_WR      = 4'h8,
        CMD_NAT_RD      = 4'h9
    } aux_cmd_e;

    typedef struct packed {
        logic [3:0]        cmd;
        logic              addr_only;
        logic [LENF_W-1:0] len_m1;
    } ctrl_t;

    typedef struct packed {
        logic [3:0]          rtype;
        logic [CNT_W-1:0]    cnt;
        logic [BUF_BITS-1:0] data;
        logic [LERR_N-1:0]   err;
    } link_rsp_t;

    function automatic logic is_i2c_cmd(input logic [3:0] cmd);
        return cmd inside {CMD_I2C_WR, CMD_I2C_RD, CMD_I2C_WSU,
                           CMD_I2C_WR_MOT, CMD_I2C_RD_MOT, CMD_I2C_WSU_MOT};
    endfunction

    function automatic logic cmd_legal(input logic [3:0] cmd, input logic aonly);
        if (is_i2c_cmd(cmd))
            return 1'b1;
        if (cmd == CMD_NAT_WR || cmd == CMD_NAT_RD)
            return !aonly;
        return 1'b0;
    endfunction

    function automatic logic [CNT_W-1:0] req_len(input ctrl_t c);
        if (c.addr_only)
            return '0;
        return CNT_W'(c.len_m1) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/aux_xact_regs.sv
module aux_xact_regs
    import aux_xact_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [REG_IDX_W-1:0] bus_word,
    input  logic [31:0]          bus_wdata,
    input  logic                 busy,
    output ctrl_t                ctrl,
    output logic [ADDR_W-1:0]    aux_addr,
    output logic [BUF_BITS-1:0]  tx_data,
    output logic [INT_N-1:0]     ien,
    output logic                 start
);

    ctrl_t wr_ctrl;
    logic  ctrl_wr;
    logic  open_wr;

    assign open_wr          = bus_wr && !busy;
    assign ctrl_wr          = open_wr && (bus_word == IDX_CTRL);
    assign wr_ctrl.cmd      = bus_wdata[CTRL_CMD_LSB +: 4];
    assign wr_ctrl.addr_only = bus_wdata[CTRL_AONLY_BIT];
    assign wr_ctrl.len_m1   = bus_wdata[LENF_W-1:0];

    assign start = ctrl_wr && bus_wdata[CTRL_GO_BIT]
                   && cmd_legal(wr_ctrl.cmd, wr_ctrl.addr_only);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            aux_addr <= '0;
            ien      <= '0;
        end else begin
            if (ctrl_wr)
                ctrl <= wr_ctrl;
            if (open_wr && bus_word == IDX_ADDR)
                aux_addr <= bus_wdata[ADDR_W-1:0];
            if (bus_wr && bus_word == IDX_IEN)
                ien <= bus_wdata[INT_N-1:0];
        end
    end

    for (genvar w = 0; w < BUF_WORDS; w++) begin : g_tx
        logic [31:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (open_wr && bus_word == REG_IDX_W'(int'(IDX_TX_BASE) + w))
                word_q <= bus_wdata;
        end
        assign tx_data[32*w +: 32] = word_q;
    end

endmodule

// File: rtl/aux_xact_seq.sv
module aux_xact_seq
    import aux_xact_pkg::*;
#(
    parameter int TIMEOUT_CYC = 400
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                lk_req_ready,
    input  logic                lk_rsp_valid,
    input  link_rsp_t           rsp,
    input  logic [SERR_N-1:0]   err_clr,
    output logic                busy,
    output logic                lk_req_valid,
    output logic                done_evt,
    output logic [SERR_N-1:0]   err_flags,
    output logic [3:0]          reply_type,
    output logic [CNT_W-1:0]    rx_cnt,
    output logic [BUF_BITS-1:0] rx_data
);

    localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_state_e;

    seq_state_e       state;
    logic [TMO_W-1:0] tmo_cnt;
    logic             expired;
    logic             got_rsp;
    logic             tmo_hit;
    logic [SERR_N-1:0] err_set;

    assign busy         = (state != S_IDLE);
    assign lk_req_valid = (state == S_REQ);
    assign expired      = busy && (tmo_cnt == TMO_W'(TIMEOUT_CYC - 1));
    assign got_rsp      = (state == S_WAIT) && lk_rsp_valid;
    assign tmo_hit      = expired && !got_rsp;
    assign done_evt     = got_rsp || tmo_hit;
    assign err_set      = {rsp.err & {LERR_N{got_rsp}}, tmo_hit};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            tmo_cnt    <= '0;
            err_flags  <= '0;
            reply_type <= '0;
            rx_cnt     <= '0;
            rx_data    <= '0;
        end else begin
            case (state)
                S_IDLE:  if (start) state <= S_REQ;
                S_REQ:   if (tmo_hit) state <= S_IDLE;
                         else if (lk_req_ready) state <= S_WAIT;
                S_WAIT:  if (done_evt) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase

            if (start)
                tmo_cnt <= '0;
            else if (busy)
                tmo_cnt <= tmo_cnt + TMO_W'(1);

            err_flags <= (err_flags & ~err_clr) | err_set;

            if (got_rsp) begin
                reply_type <= rsp.rtype;
                rx_cnt     <= rsp.cnt;
                rx_data    <= rsp.data;
            end else if (tmo_hit) begin
                rx_cnt     <= '0;
            end
        end
    end

endmodule

// File: rtl/aux_xact_evt.sv
module aux_xact_evt
    import aux_xact_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hpd_in,
    input  logic             sink_irq,
    input  logic             done_evt,
    input  logic [INT_N-1:0] flag_clr,
    input  logic [INT_N-1:0] ien,
    output logic             hpd_level,
    output logic [INT_N-1:0] flags,
    output logic             irq
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hpd_prev;
    logic [INT_N-1:0]       flag_set;

    assign hpd_level = sync_q[SYNC_STAGES-1];

    always_comb begin
        flag_set             = '0;
        flag_set[INT_DONE]   = done_evt;
        flag_set[INT_PLUG]   = hpd_level && !hpd_prev;
        flag_set[INT_UNPLUG] = !hpd_level && hpd_prev;
        flag_set[INT_SINK]   = sink_irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            hpd_prev <= 1'b0;
            flags    <= '0;
        end else begin
            sync_q   <= {sync_q[SYNC_STAGES-2:0], hpd_in};
            hpd_prev <= hpd_level;
            flags    <= (flags & ~flag_clr) | flag_set;
        end
    end

    assign irq = |(flags & ien);

endmodule

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl
    import aux_xact_pkg::*;
#(
    parameter int AUX_ADDR_W  = 20,
    parameter int TIMEOUT_CYC = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [REG_IDX_W-1:0]  bus_word,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  irq,
    output logic                  lk_req_valid,
    input  logic                  lk_req_ready,
    output logic [3:0]            lk_req_cmd,
    output logic [AUX_ADDR_W-1:0] lk_req_addr,
    output logic [CNT_W-1:0]      lk_req_len,
    output logic [BUF_BITS-1:0]   lk_req_data,
    input  logic                  lk_rsp_valid,
    input  logic [3:0]            lk_rsp_type,
    input  logic [CNT_W-1:0]      lk_rsp_len,
    input  logic [BUF_BITS-1:0]   lk_rsp_data,
    input  logic [LERR_N-1:0]     lk_rsp_err,
    input  logic                  hpd_in,
    input  logic                  sink_irq
);

    ctrl_t               ctrl;
    logic [INT_N-1:0]    ien;
    logic                start;
    logic                busy;
    logic                done_evt;
    logic [SERR_N-1:0]   err_flags;
    logic [SERR_N-1:0]   err_clr;
    logic [3:0]          reply_type;
    logic [CNT_W-1:0]    rx_cnt;
    logic [BUF_BITS-1:0] rx_data;
    logic [INT_N-1:0]    irq_flags;
    logic [INT_N-1:0]    flag_clr;
    logic                hpd_level;
    link_rsp_t           rsp;

    assign rsp = '{rtype: lk_rsp_type, cnt: lk_rsp_len, data: lk_rsp_data, err: lk_rsp_err};

    assign err_clr  = (bus_wr && bus_word == IDX_STAT)
                      ? bus_wdata[STAT_ERR_LSB +: SERR_N] : '0;
    assign flag_clr = (bus_wr && bus_word == IDX_IFLAG)
                      ? bus_wdata[INT_N-1:0] : '0;

    aux_xact_regs #(.ADDR_W(AUX_ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .ctrl      (ctrl),
        .aux_addr  (lk_req_addr),
        .tx_data   (lk_req_data),
        .ien       (ien),
        .start     (start)
    );

    aux_xact_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .lk_req_ready (lk_req_ready),
        .lk_rsp_valid (lk_rsp_valid),
        .rsp          (rsp),
        .err_clr      (err_clr),
        .busy         (busy),
        .lk_req_valid (lk_req_valid),
        .done_evt     (done_evt),
        .err_flags    (err_flags),
        .reply_type   (reply_type),
        .rx_cnt       (rx_cnt),
        .rx_data      (rx_data)
    );

    aux_xact_evt #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .hpd_in    (hpd_in),
        .sink_irq  (sink_irq),
        .done_evt  (done_evt),
        .flag_clr  (flag_clr),
        .ien       (ien),
        .hpd_level (hpd_level),
        .flags     (irq_flags),
        .irq       (irq)
    );

    assign lk_req_cmd = ctrl.cmd;
    assign lk_req_len = req_len(ctrl);

    always_comb begin
        bus_rdata = '0;
        case (bus_word)
            IDX_ADDR: bus_rdata[AUX_ADDR_W-1:0] = lk_req_addr;
            IDX_CTRL: begin
                bus_rdata[LENF_W-1:0]          = ctrl.len_m1;
                bus_rdata[CTRL_CMD_LSB +: 4]   = ctrl.cmd;
                bus_rdata[CTRL_AONLY_BIT]      = ctrl.addr_only;
                bus_rdata[CTRL_GO_BIT]         = busy;
            end
            IDX_STAT: begin
                bus_rdata[CNT_W-1:0]               = rx_cnt;
                bus_rdata[STAT_ERR_LSB +: SERR_N]  = err_flags;
                bus_rdata[STAT_TYPE_LSB +: 4]      = reply_type;
                bus_rdata[STAT_HPD_BIT]            = hpd_level;
            end
            IDX_IEN:   bus_rdata[INT_N-1:0] = ien;
            IDX_IFLAG: bus_rdata[INT_N-1:0] = irq_flags;
            default: begin
                if (bus_word[3:2] == IDX_TX_BASE[3:2])
                    bus_rdata = lk_req_data[32*bus_word[1:0] +: 32];
                else if (bus_word[3:2] == IDX_RX_BASE[3:2])
                    bus_rdata = rx_data[32*bus_word[1:0] +: 32];
            end
        endcase
    end

endmodule

// File: rtl/aux_xact_ctrl_chk.sv
module aux_xact_ctrl_chk
    import aux_xact_pkg::*;
#(
    parameter int TIMEOUT_CYC = 400
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic [REG_IDX_W-1:0] bus_word,
    input logic [31:0]          bus_wdata,
    input logic                 busy,
    input logic                 done_evt,
    input logic                 lk_req_valid,
    input logic                 lk_req_ready,
    input logic [3:0]           lk_req_cmd,
    input logic [INT_N-1:0]     iflags
);

    localparam int BW = $clog2(TIMEOUT_CYC + 2);

    logic [BW-1:0] busy_cyc;

    always_ff @(posedge clk) begin
        if (rst || !busy)
            busy_cyc <= '0;
        else
            busy_cyc <= busy_cyc + BW'(1);
    end

    // R7: a transaction never stays busy longer than the reply window
    a_r7_bounded_busy: assert property (@(posedge clk) disable iff (rst)
        busy_cyc <= BW'(TIMEOUT_CYC));

    // R12: no request is offered while idle
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !lk_req_valid);

    // R8: completion raises the done flag
    a_r8_done_flag: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> iflags[INT_DONE]);

    // R4: the go bit drops after completion
    a_r4_go_selfclear: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> !busy);

    // R3: an illegal go write does not start anything
    a_r3_illegal_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word == IDX_CTRL && bus_wdata[CTRL_GO_BIT] && !busy
         && !cmd_legal(bus_wdata[CTRL_CMD_LSB +: 4], bus_wdata[CTRL_AONLY_BIT]))
        |=> !busy);

    // R1: the command is held while the request waits for acceptance
    a_r1_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (lk_req_valid && !lk_req_ready) |=> $stable(lk_req_cmd));

endmodule

bind aux_xact_ctrl aux_xact_ctrl_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_word     (bus_word),
    .bus_wdata    (bus_wdata),
    .busy         (busy),
    .done_evt     (done_evt),
    .lk_req_valid (lk_req_valid),
    .lk_req_ready (lk_req_ready),
    .lk_req_cmd   (lk_req_cmd),
    .iflags       (irq_flags)
);

// File: tb/tb_aux_xact_ctrl.sv
`timescale 1ns/1ps
module tb_aux_xact_ctrl;

    localparam int TMO = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_word = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq;
    logic         lk_req_valid;
    logic         lk_req_ready = 1'b0;
    logic [3:0]   lk_req_cmd;
    logic [19:0]  lk_req_addr;
    logic [4:0]   lk_req_len;
    logic [127:0] lk_req_data;
    logic         lk_rsp_valid = 1'b0;
    logic [3:0]   lk_rsp_type = '0;
    logic [4:0]   lk_rsp_len = '0;
    logic [127:0] lk_rsp_data = '0;
    logic [2:0]   lk_rsp_err = '0;
    logic         hpd_in = 1'b0;
    logic         sink_irq = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    aux_xact_ctrl #(.TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .lk_req_valid(lk_req_valid), .lk_req_ready(lk_req_ready),
        .lk_req_cmd(lk_req_cmd), .lk_req_addr(lk_req_addr),
        .lk_req_len(lk_req_len), .lk_req_data(lk_req_data),
        .lk_rsp_valid(lk_rsp_valid), .lk_rsp_type(lk_rsp_type),
        .lk_rsp_len(lk_rsp_len), .lk_rsp_data(lk_rsp_data),
        .lk_rsp_err(lk_rsp_err), .hpd_in(hpd_in), .sink_irq(sink_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] w, output logic [31:0] d);
        bus_word = w;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cw(input logic [3:0] cmd, input logic ao,
                                       input logic [3:0] lm1, input logic go);
        return {15'b0, go, 3'b0, ao, cmd, 4'b0, lm1};
    endfunction

    task automatic serve(input string req, input logic [3:0] ecmd,
                         input logic [19:0] eaddr, input logic [4:0] elen,
                         input logic [127:0] edata, input bit cmp_data,
                         input logic [3:0] rt, input logic [4:0] rl,
                         input logic [127:0] rdat, input logic [2:0] re);
        int n = 0;
        while (!lk_req_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(req, "request valid", lk_req_valid, 1);
        chk("R1", "request cmd", lk_req_cmd, ecmd);
        chk("R1", "request addr", lk_req_addr, eaddr);
        chk("R1", "request len", lk_req_len, elen);
        if (cmp_data) chk("R2", "request data", lk_req_data, edata);
        lk_req_ready = 1'b1;
        @(negedge clk);
        lk_req_ready = 1'b0;
        @(negedge clk);
        lk_rsp_valid = 1'b1; lk_rsp_type = rt; lk_rsp_len = rl;
        lk_rsp_data = rdat; lk_rsp_err = re;
        @(negedge clk);
        lk_rsp_valid = 1'b0; lk_rsp_err = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int w = 0; w < 16; w++) begin
            rd(4'(w), d);
            chk("R12", $sformatf("reset reg %0d", w), d, 0);
        end
        chk("R12", "reset irq", irq, 0);
        chk("R12", "reset req valid", lk_req_valid, 0);
    endtask

    task automatic t_native_write();
        logic [31:0] d;
        logic [31:0] tw [4] = '{32'h44332211, 32'h88776655, 32'hCCBBAA99, 32'h00FFEEDD};
        wr(4'd4, 32'hF);
        wr(4'd0, 32'h12345);
        for (int w = 0; w < 4; w++) wr(4'(8 + w), tw[w]);
        wr(4'd1, cw(4'h8, 1'b0, 4'd4, 1'b1));
        rd(4'd1, d);
        chk("R4", "go set while busy", d[16], 1);
        serve("R1", 4'h8, 20'h12345, 5'd5, {tw[3], tw[2], tw[1], tw[0]}, 1'b1,
              4'h0, 5'd0, '0, 3'b0);
        rd(4'd1, d);
        chk("R4", "go self-cleared", d, 32'h0804);
        rd(4'd2, d);
        chk("R5", "native ack status", d, 32'h0);
        rd(4'd4, d);
        chk("R8", "done flag after write", d, 32'h1);
    endtask

    task automatic t_i2c_read16();
        logic [31:0]  d;
        logic [127:0] pat;
        for (int k = 0; k < 16; k++) pat[8*k +: 8] = 8'hA0 + 8'(k);
        wr(4'd4, 32'hF);
        wr(4'd0, 32'h00050);
        wr(4'd1, cw(4'h5, 1'b0, 4'd15, 1'b1));
        serve("R1", 4'h5, 20'h00050, 5'd16, '0, 1'b0, 4'h0, 5'd16, pat, 3'b0);
        rd(4'd2, d);
        chk("R5", "read count 16", d, 32'h10);
        for (int w = 0; w < 4; w++) begin
            rd(4'(12 + w), d);
            chk("R5", $sformatf("rx word %0d", w), d, pat[32*w +: 32]);
        end
        rd(4'd4, d);
        chk("R8", "done flag after read", d, 32'h1);
    endtask

    task automatic t_addr_only();
        logic [31:0] d;
        wr(4'd4, 32'hF);
        wr(4'd1, cw(4'h6, 1'b1, 4'd3, 1'b1));
        serve("R3", 4'h6, 20'h00050, 5'd0, '0, 1'b0, 4'h4, 5'd0, '0, 3'b0);
        rd(4'd2, d);
        chk("R5", "i2c nack type", d, 32'h40000);
    endtask

    task automatic t_illegal();
        logic [31:0] d;
        wr(4'd4, 32'hF);
        wr(4'd1, cw(4'h9, 1'b1, 4'd0, 1'b1));
        rd(4'd1, d);
        chk("R3", "native addr-only go dropped", d[16], 0);
        chk("R3", "native addr-only no request", lk_req_valid, 0);
        wr(4'd1, cw(4'h3, 1'b0, 4'd2, 1'b1));
        rd(4'd1, d);
        chk("R3", "undefined cmd go dropped", d[16], 0);
        repeat (3) @(negedge clk);
        chk("R3", "undefined cmd no request", lk_req_valid, 0);
        rd(4'd4, d);
        chk("R3", "no done flag", d, 0);
    endtask

    task automatic t_busy_lock();
        logic [31:0] d;
        wr(4'd0, 32'h00ABC);
        wr(4'd1, cw(4'h9, 1'b0, 4'd1, 1'b1));
        wr(4'd1, cw(4'h1, 1'b0, 4'd7, 1'b0));
        wr(4'd0, 32'h55555);
        rd(4'd1, d);
        chk("R4", "ctrl write ignored when busy", d, 32'h10901);
        rd(4'd0, d);
        chk("R4", "addr write ignored when busy", d, 32'h00ABC);
        serve("R4", 4'h9, 20'h00ABC, 5'd2, '0, 1'b0, 4'h2, 5'd0, '0, 3'b0);
        rd(4'd2, d);
        chk("R5", "native defer type", d, 32'h20000);
    endtask

    task automatic t_errors();
        logic [31:0] d;
        wr(4'd1, cw(4'h0, 1'b0, 4'd0, 1'b1));
        serve("R6", 4'h0, 20'h00ABC, 5'd1, '0, 1'b0, 4'h8, 5'd0, '0, 3'b101);
        rd(4'd2, d);
        chk("R6", "rx err and no-stop flags", d, 32'h80A00);
        wr(4'd2, 32'h200);
        rd(4'd2, d);
        chk("R6", "partial clear", d, 32'h80800);
        wr(4'd2, 32'hF00);
        rd(4'd2, d);
        chk("R6", "full clear", d, 32'h80000);
    endtask

    task automatic t_timeout();
        logic [31:0] d;
        wr(4'd4, 32'hF);
        wr(4'd1, cw(4'h8, 1'b0, 4'd0, 1'b1));
        repeat (TMO - 2) @(negedge clk);
        rd(4'd1, d);
        chk("R7", "still busy before window ends", d[16], 1);
        repeat (3) @(negedge clk);
        rd(4'd1, d);
        chk("R7", "go cleared after window", d[16], 0);
        chk("R7", "request withdrawn", lk_req_valid, 0);
        rd(4'd2, d);
        chk("R7", "timeout flag and zero count", {d[11:8], 3'b0, d[4:0]}, {4'h1, 8'h00});
        rd(4'd4, d);
        chk("R7", "done after timeout", d, 32'h1);
        wr(4'd4, 32'hF);
        @(negedge clk);
        lk_rsp_valid = 1'b1; lk_rsp_type = 4'h1; lk_rsp_len = 5'd3;
        @(negedge clk);
        lk_rsp_valid = 1'b0;
        rd(4'd2, d);
        chk("R7", "late reply ignored", d, 32'h80100);
        rd(4'd4, d);
        chk("R7", "late reply no done", d, 0);
        wr(4'd2, 32'hF00);
    endtask

    task automatic t_hpd();
        logic [31:0] d;
        wr(4'd4, 32'hF);
        hpd_in = 1'b1;
        repeat (5) @(negedge clk);
        rd(4'd2, d);
        chk("R9", "hpd level high", d[24], 1);
        rd(4'd4, d);
        chk("R9", "plug flag", d, 32'h2);
        wr(4'd4, 32'hF);
        hpd_in = 1'b0;
        repeat (5) @(negedge clk);
        rd(4'd2, d);
        chk("R9", "hpd level low", d[24], 0);
        rd(4'd4, d);
        chk("R9", "unplug flag", d, 32'h4);
    endtask

    task automatic t_sink_irq();
        logic [31:0] d;
        wr(4'd4, 32'hF);
        @(negedge clk); sink_irq = 1'b1;
        @(negedge clk); sink_irq = 1'b0;
        rd(4'd4, d);
        chk("R10", "sink flag", d, 32'h8);
        chk("R11", "irq masked", irq, 0);
    endtask

    task automatic t_irq_gate();
        logic [31:0] d;
        wr(4'd3, 32'h8);
        chk("R11", "irq enabled sink", irq, 1);
        wr(4'd3, 32'h7);
        chk("R11", "irq other enables only", irq, 0);
        wr(4'd3, 32'h8);
        wr(4'd4, 32'h8);
        rd(4'd4, d);
        chk("R11", "flag cleared by one", d, 0);
        chk("R11", "irq low after clear", irq, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_native_write();
        t_i2c_read16();
        t_addr_only();
        t_illegal();
        t_busy_lock();
        t_errors();
        t_timeout();
        t_hpd();
        t_sink_irq();
        t_irq_gate();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule